// File: doc/BRIEF.md
# Accumulator Read Scaler and Saturating Limiter

This block sits on the read side of a signed fractional accumulator. The accumulator is 56 bits wide: an 8-bit extension field on top, a 24-bit upper word and a 24-bit lower word. The block turns it into a 24-bit word for a data bus. Values use two's complement with the binary point just below the sign bit. A read request picks one of two kinds of view:

- The whole accumulator. Here a scaling mode first applies a one-bit left shift, a one-bit right shift or no shift. The 24-bit window is then taken from the upper word position. If the scaled value does not fit in that window, the output saturates to the largest positive or most negative 24-bit fraction, and a limit flag is raised.
- One of the three raw sub-fields. These are neither scaled nor limited.

A simple load port fills the accumulator, and its contents are visible on an output. A read only shapes the value driven onto the bus; the stored accumulator never changes. The result of a read is registered. It holds until the next read.

Top module: `acc_read_limiter`

## Requirements
- R1: After reset, busWord, limitFlag, busValid and accValue are all zero.
- R2: When accLoad is high at a clock edge, accIn is stored, and accValue shows it after that edge.
- R3: A read is taken at an edge where readEn is high. Its result appears on busWord and limitFlag after that same edge. busValid is high for exactly the one cycle after each such edge and low otherwise. readSel encodes 2'b00 = whole accumulator, 2'b01 = extension field, 2'b10 = upper word, 2'b11 = lower word.
- R4: For whole-accumulator reads, scaleMode 2'b00 means no shift and 2'b11 behaves the same way. 2'b01 means an arithmetic right shift by one, with bit 55 copied into the top. 2'b10 means a left shift by one, with zero entering bit 0. The output window is bits [47:24] of the shifted 56-bit value.
- R5: A whole-accumulator read limits when the shifted value lies outside [-2^47, 2^47) (in units of bit 0). The output is then 24'h7FFFFF if accumulator bit 55 is 0, or 24'h800000 if it is 1, and limitFlag is 1.
- R6: A whole-accumulator read whose scaled value fits returns the window unchanged, with limitFlag 0.
- R7: An upper-word read returns accumulator bits [47:24] unchanged, whatever scaleMode is, with limitFlag 0. For example, +1.0 (56'h00_800000_000000) reads as 24'h800000.
- R8: A lower-word read returns bits [23:0]. An extension read returns bits [55:48], sign-extended to 24 bits. Both ignore scaleMode and leave limitFlag 0.
- R9: A read of any kind leaves accValue unchanged.
- R10: While readEn is low, busWord and limitFlag hold their values, whatever readSel and scaleMode do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accLoad | input | 1 | Store accIn into the accumulator |
| accIn | input | 56 | Accumulator load value |
| readEn | input | 1 | Take a read this cycle |
| readSel | input | 2 | View selector (see R3) |
| scaleMode | input | 2 | Scaling mode (see R4) |
| busWord | output | 24 | Registered read result |
| limitFlag | output | 1 | Result was saturated |
| busValid | output | 1 | One-cycle pulse after a read |
| accValue | output | 56 | Stored accumulator contents |

## Verification
The bench builds the block with its default widths: a 24-bit word and an 8-bit extension. This brings both clamp values, the sign-extended extension view and the full 56-bit shift range within reach. The expected values for whole-accumulator reads come from ordinary signed integer scaling and a range test, not from the bit-level guard logic. The chosen values make each scaling mode cross the range boundary both ways. One case is a left shift that loses the sign bit itself while the guard bits still agree.

// File: rtl/acc_read_pkg.sv
package acc_read_pkg;

  typedef enum logic [1:0] {
    SEL_WHOLE = 2'b00,
    SEL_EXT   = 2'b01,
    SEL_UPPER = 2'b10,
    SEL_LOWER = 2'b11
  } readSel_e;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;

  typedef struct packed {
    logic capture;
    logic whole;
    logic ext;
    logic upper;
    logic lower;
    logic shDown;
    logic shUp;
  } strobe_t;

endpackage

// File: rtl/acc_read_ctrl.sv
module acc_read_ctrl
  import acc_read_pkg::*;
(
  input  logic       readEn,
  input  logic [1:0] readSel,
  input  logic [1:0] scaleMode,
  output strobe_t    stb
);

  readSel_e selDec;
  scale_e   sclDec;

  always_comb begin
    selDec = readSel_e'(readSel);
    sclDec = scale_e'(scaleMode);
    stb = '0;
    stb.capture = readEn;
    unique case (selDec)
      SEL_WHOLE: stb.whole = readEn;
      SEL_EXT:   stb.ext   = readEn;
      SEL_UPPER: stb.upper = readEn;
      SEL_LOWER: stb.lower = readEn;
      default:   stb.whole = readEn;
    endcase
    // scaling only matters for the whole-accumulator view
    stb.shDown = readEn && (selDec == SEL_WHOLE) && (sclDec == SCL_DOWN);
    stb.shUp   = readEn && (selDec == SEL_WHOLE) && (sclDec == SCL_UP);
  end

  // R4
  always_comb begin
    shift_dir_chk: assert (!(stb.shDown && stb.shUp))
      else $error("both shift directions strobed");
  end

endmodule

// File: rtl/acc_read_dpath.sv
module acc_read_dpath
  import acc_read_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int EXT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accLoad,
  input  logic [EXT_W+2*WORD_W-1:0]     accIn,
  input  strobe_t                       stb,
  output logic [WORD_W-1:0]             busWord,
  output logic                          limitFlag,
  output logic                          busValid,
  output logic [EXT_W+2*WORD_W-1:0]     accValue
);

  localparam int ACC_W   = EXT_W + 2 * WORD_W;
  localparam int GUARD_W = EXT_W + 1;
  localparam int WIN_TOP = 2 * WORD_W - 1;
  localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] MAX_NEG = {1'b1, {(WORD_W-1){1'b0}}};

  logic [ACC_W-1:0]   accReg;
  logic [ACC_W-1:0]   shifted;
  logic [GUARD_W-1:0] guard;
  logic               lostSign;
  logic               limitHit;
  logic [WORD_W-1:0]  window;
  logic [WORD_W-1:0]  clampVal;
  logic [WORD_W-1:0]  extWord;
  logic [WORD_W-1:0]  nextWord;

  // extension view, sign-extended when narrower than a word
  generate
    if (EXT_W < WORD_W) begin : g_extPad
      assign extWord = {{(WORD_W-EXT_W){accReg[ACC_W-1]}}, accReg[ACC_W-1 -: EXT_W]};
    end else begin : g_extTrim
      assign extWord = accReg[ACC_W-1 -: WORD_W];
    end
  endgenerate

  always_comb begin
    shifted = accReg;
    if (stb.shDown)    shifted = {accReg[ACC_W-1], accReg[ACC_W-1:1]};
    else if (stb.shUp) shifted = {accReg[ACC_W-2:0], 1'b0};
    guard    = shifted[ACC_W-1 -: GUARD_W];
    lostSign = stb.shUp && (accReg[ACC_W-1] != accReg[ACC_W-2]);
    limitHit = stb.whole && (lostSign || !((guard == '0) || (guard == '1)));
    window   = shifted[WIN_TOP -: WORD_W];
    clampVal = accReg[ACC_W-1] ? MAX_NEG : MAX_POS;
    nextWord = window;
    if (stb.ext)        nextWord = extWord;
    else if (stb.upper) nextWord = accReg[WIN_TOP -: WORD_W];
    else if (stb.lower) nextWord = accReg[WORD_W-1:0];
    else if (limitHit)  nextWord = clampVal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accReg    <= '0;
      busWord   <= '0;
      limitFlag <= 1'b0;
      busValid  <= 1'b0;
    end else begin
      if (accLoad) accReg <= accIn;
      busValid <= stb.capture;
      if (stb.capture) begin
        busWord   <= nextWord;
        limitFlag <= limitHit;
      end
    end
  end

  assign accValue = accReg;

  // R5
  clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limitFlag |-> (busWord == MAX_POS || busWord == MAX_NEG));

  // R7
  subview_nolimit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.capture && !stb.whole) |=> !limitFlag);

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accLoad |=> $stable(accValue));

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.capture |=> ($stable(busWord) && $stable(limitFlag)));

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.capture |=> busValid);

endmodule

// File: rtl/acc_read_limiter.sv
module acc_read_limiter
  import acc_read_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int EXT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accLoad,
  input  logic [EXT_W+2*WORD_W-1:0] accIn,
  input  logic                      readEn,
  input  logic [1:0]                readSel,
  input  logic [1:0]                scaleMode,
  output logic [WORD_W-1:0]         busWord,
  output logic                      limitFlag,
  output logic                      busValid,
  output logic [EXT_W+2*WORD_W-1:0] accValue
);

  strobe_t stb;

  acc_read_ctrl u_ctrl (
    .readEn    (readEn),
    .readSel   (readSel),
    .scaleMode (scaleMode),
    .stb       (stb)
  );

  acc_read_dpath #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accLoad   (accLoad),
    .accIn     (accIn),
    .stb       (stb),
    .busWord   (busWord),
    .limitFlag (limitFlag),
    .busValid  (busValid),
    .accValue  (accValue)
  );

endmodule

// File: tb/tb_acc_read_limiter.sv
module tb_acc_read_limiter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        accLoad;
  logic [55:0] accIn;
  logic        readEn;
  logic [1:0]  readSel;
  logic [1:0]  scaleMode;
  logic [23:0] busWord;
  logic        limitFlag;
  logic        busValid;
  logic [55:0] accValue;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_read_limiter dut (
    .clk(clk), .rst_n(rst_n), .accLoad(accLoad), .accIn(accIn),
    .readEn(readEn), .readSel(readSel), .scaleMode(scaleMode),
    .busWord(busWord), .limitFlag(limitFlag), .busValid(busValid),
    .accValue(accValue)
  );

  task automatic check(string req, string what, logic [55:0] act, logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected {flag, word} from the requirements, using integer scaling
  function automatic logic [24:0] model(logic [55:0] a, logic [1:0] sel, logic [1:0] md);
    longint v;
    longint lim;
    logic [63:0] bits;
    lim = longint'(1) <<< 47;
    case (sel)
      2'b01: return {1'b0, {16{a[55]}}, a[55:48]};
      2'b10: return {1'b0, a[47:24]};
      2'b11: return {1'b0, a[23:0]};
      default: begin
        v = $signed({{8{a[55]}}, a});
        if (md == 2'b01)      v = v >>> 1;
        else if (md == 2'b10) v = v * 2;
        if (v >= lim)         return {1'b1, 24'h7FFFFF};
        else if (v < -lim)    return {1'b1, 24'h800000};
        bits = v;
        return {1'b0, bits[47:24]};
      end
    endcase
  endfunction

  task automatic load_acc(logic [55:0] val);
    @(negedge clk);
    accLoad = 1'b1;
    accIn   = val;
    @(negedge clk);
    accLoad = 1'b0;
    accIn   = '0;
    check("R2", "accValue after load", accValue, val);
  endtask

  task automatic do_read(logic [1:0] sel, logic [1:0] md);
    @(negedge clk);
    readEn    = 1'b1;
    readSel   = sel;
    scaleMode = md;
    @(negedge clk);
    readEn    = 1'b0;
  endtask

  task automatic test_reset();
    check("R1", "busWord", {32'h0, busWord}, 56'h0);
    check("R1", "limitFlag", {55'h0, limitFlag}, 56'h0);
    check("R1", "busValid", {55'h0, busValid}, 56'h0);
    check("R1", "accValue", accValue, 56'h0);
  endtask

  task automatic test_whole(logic [55:0] val);
    logic [24:0] exp;
    load_acc(val);
    for (int m = 0; m < 4; m++) begin
      exp = model(val, 2'b00, 2'(m));
      do_read(2'b00, 2'(m));
      // R4 R5 R6: word and flag of a whole-accumulator read
      check(exp[24] ? "R5" : "R6", "whole word", {32'h0, busWord}, {32'h0, exp[23:0]});
      check(exp[24] ? "R5" : "R4", "whole flag", {55'h0, limitFlag}, {55'h0, exp[24]});
      check("R3", "busValid pulse", {55'h0, busValid}, 56'h1);
      check("R9", "acc unchanged", accValue, val);
    end
  endtask

  task automatic test_subviews(logic [55:0] val);
    logic [24:0] exp;
    load_acc(val);
    for (int s = 1; s < 4; s++) begin
      for (int m = 0; m < 3; m += 2) begin
        exp = model(val, 2'(s), 2'(m));
        do_read(2'(s), 2'(m));
        check(s == 2 ? "R7" : "R8", "subview word", {32'h0, busWord}, {32'h0, exp[23:0]});
        check(s == 2 ? "R7" : "R8", "subview flag", {55'h0, limitFlag}, 56'h0);
        check("R9", "acc unchanged", accValue, val);
      end
    end
  endtask

  task automatic test_hold();
    logic [23:0] held;
    load_acc(56'h00_800000_000000);
    do_read(2'b00, 2'b00);
    held = busWord;
    check("R5", "limited before hold", {55'h0, limitFlag}, 56'h1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      readSel   = 2'(i);
      scaleMode = 2'(3 - i);
      check("R3", "busValid low when idle", {55'h0, busValid}, 56'h0);
      check("R10", "busWord held", {32'h0, busWord}, {32'h0, held});
      check("R10", "limitFlag held", {55'h0, limitFlag}, 56'h1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; accLoad = 1'b0; accIn = '0;
    readEn = 1'b0; readSel = 2'b00; scaleMode = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_whole(56'h00_123456_789ABC);
    test_whole(56'h00_800000_000000);
    test_whole(56'hFE_000000_000000);
    test_whole(56'h80_000000_000001);
    test_whole(56'hFF_800000_000000);
    test_whole(56'h00_7FFFFF_FFFFFF);
    test_whole(56'h00_400000_000000);
    test_subviews(56'h00_800000_000000);
    test_subviews(56'hA5_C3D2E1_F0A5B4);
    test_subviews(56'h3C_7F0001_00FFEE);
    test_hold();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule